// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer with Recency Replacement

This block caches recent page-to-frame translations. A virtual page number comes in on the lookup port. In the same cycle the block answers with a hit flag and the matching physical frame number. The page number is compared against every stored entry at once. When no valid entry holds the page, the block raises a refill request. The surrounding logic then walks the page table, which costs one more memory reference, and returns the result on the refill port. The block installs that page-to-frame pair so that the next access to the page hits. The page offset never enters the block; the logic around it passes the offset through unchanged.

Replacement follows a true recency order. Each entry carries a rank from 0 (most recent) to ENTRIES-1 (least recent), and the ranks always form a permutation. A hit moves the matched entry to rank 0. A refill goes to the lowest-indexed invalid entry if one exists. Otherwise it evicts the entry ranked least recent. A flush input clears every entry when the running context changes. Two free-running counters record hits and misses, so the hit ratio can be compared with a model.

Top module: `tlbLru`

## Requirements
- R1: When `lookupValid` is high and a valid entry stores `lookupVpn`, `hit` is 1 and `frame` shows that entry's frame number in the same cycle, with no clock edge in between.
- R2: An invalid entry never produces a hit. After reset every entry is invalid, so every lookup misses.
- R3: `refillReq` equals `lookupValid` AND NOT `hit`. `hit` is 0 whenever `lookupValid` is 0.
- R4: A refill (`refillValid` high, `flush` low) installs the pair `refillVpn`/`refillPfn` at the next rising edge as a valid entry. A later lookup of that page hits with that frame.
- R5: A hit with no refill or flush in the same cycle makes the matched entry rank 0 at the next edge. Every entry that was more recent than it moves down one rank, and all other ranks stay as they were. Refill has priority over this update.
- R6: The refill target is the lowest-indexed invalid entry when one exists. Otherwise it is the entry at rank ENTRIES-1. The installed entry becomes rank 0, and the ranks of the other entries shift as in R5.
- R7: `flush` invalidates every entry at the next edge and resets the ranks so that entry i has rank i.
- R8: When `flush` and `refillValid` are high in the same cycle, the flush wins and the refill pair is not installed.
- R9: `hitCount` increments on each cycle with `lookupValid` and `hit`. `missCount` increments on each cycle with `lookupValid` and no `hit`. Both counters are 0 after reset and wrap at 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupVpn | input | VPN_W | Virtual page number to translate |
| hit | output | 1 | Valid matching entry found (combinational) |
| frame | output | PFN_W | Frame number of the matching entry; 0 on a miss |
| refillReq | output | 1 | Lookup missed; a page table walk is needed |
| refillValid | input | 1 | Install a new translation at the next edge |
| refillVpn | input | VPN_W | Page number to install |
| refillPfn | input | PFN_W | Frame number to install |
| flush | input | 1 | Invalidate all entries at the next edge |
| hitCount | output | CNT_W | Count of lookup hits |
| missCount | output | CNT_W | Count of lookup misses |

## Verification
A wrong rank stays hidden at first. It shows at the ports only once all entries are full and a refill evicts the wrong page. The next lookup of that page then misses where a hit is due, or the reverse. That can happen many cycles after the bad update. For this reason the bench runs a long sequence of lookups over more pages than there are entries, with a bench-side recency model. It compares `hit` and `frame` on every lookup, so a stray rank is caught on the first eviction that it affects. A valid bit or payload that is stored wrongly shows in the same cycle as the lookup that touches it. Flush and the flush-beats-refill rule are checked by looking up afterwards the pages that must now miss.

// File: rtl/tlbPkg.sv
package tlbPkg;
  typedef struct packed {
    logic flush;
    logic fill;
    logic touch;
    logic countHit;
    logic countMiss;
  } tlbStrobeT;
endpackage

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlbPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lookupValid,
  input  logic [VPN_W-1:0]         lookupVpn,
  input  logic [VPN_W-1:0]         refillVpn,
  input  logic [PFN_W-1:0]         refillPfn,
  input  tlbStrobeT                strobe,
  input  logic [IDX_W-1:0]         fillIdx,
  input  logic [IDX_W-1:0]         touchIdx,
  output logic [ENTRIES-1:0]       validVec,
  output logic [ENTRIES-1:0]       matchVec,
  output logic [ENTRIES*IDX_W-1:0] rankFlat,
  output logic                     hit,
  output logic [PFN_W-1:0]         frame
);
  logic [VPN_W-1:0] entVpn [ENTRIES];
  logic [PFN_W-1:0] entPfn [ENTRIES];
  logic [IDX_W-1:0] rank   [ENTRIES];

  logic             moveEn;
  logic [IDX_W-1:0] pivotIdx;
  logic [IDX_W-1:0] pivotRank;

  assign moveEn    = strobe.fill | strobe.touch;
  assign pivotIdx  = strobe.fill ? fillIdx : touchIdx;
  assign pivotRank = rank[pivotIdx];

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    assign matchVec[i] = lookupValid && validVec[i] && (entVpn[i] == lookupVpn);
    assign rankFlat[i*IDX_W +: IDX_W] = rank[i];

    always_ff @(posedge clk) begin
      if (!rstN || strobe.flush) begin
        validVec[i] <= 1'b0;
        rank[i]     <= IDX_W'(i);
      end else begin
        if (strobe.fill && fillIdx == IDX_W'(i)) begin
          validVec[i] <= 1'b1;
          entVpn[i]   <= refillVpn;
          entPfn[i]   <= refillPfn;
        end
        if (moveEn) begin
          if (pivotIdx == IDX_W'(i))
            rank[i] <= '0;
          else if (rank[i] < pivotRank)
            rank[i] <= rank[i] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    frame = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (matchVec[i]) frame = frame | entPfn[i];
  end

  assign hit = |matchVec;

  logic [ENTRIES-1:0] rankSeen;
  always_comb begin
    rankSeen = '0;
    for (int i = 0; i < ENTRIES; i++) rankSeen[rank[i]] = 1'b1;
  end

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (validVec == '0)); // R7
  AST_RANK_PERMUTATION: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rankSeen) == ENTRIES); // R5
  AST_PIVOT_MRU: assert property (@(posedge clk) disable iff (!rstN)
    (moveEn && !strobe.flush) |=> (rank[$past(pivotIdx)] == '0)); // R6
  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fill && !strobe.flush) |=> validVec[$past(fillIdx)]); // R4
  AST_NO_LOOKUP_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !hit); // R3
endmodule

// File: rtl/tlbControl.sv
module tlbControl
  import tlbPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lookupValid,
  input  logic                     refillValid,
  input  logic                     flush,
  input  logic [ENTRIES-1:0]       validVec,
  input  logic [ENTRIES-1:0]       matchVec,
  input  logic [ENTRIES*IDX_W-1:0] rankFlat,
  input  logic                     hit,
  output tlbStrobeT                strobe,
  output logic [IDX_W-1:0]         fillIdx,
  output logic [IDX_W-1:0]         touchIdx,
  output logic [CNT_W-1:0]         hitCount,
  output logic [CNT_W-1:0]         missCount
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic             anyFree;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] oldIdx;

  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!validVec[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
  end

  always_comb begin
    oldIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (rankFlat[i*IDX_W +: IDX_W] == OLDEST) oldIdx = IDX_W'(i);
  end

  always_comb begin
    touchIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (matchVec[i]) touchIdx = IDX_W'(i);
  end

  assign fillIdx = anyFree ? freeIdx : oldIdx;

  always_comb begin
    strobe.flush     = flush;
    strobe.fill      = refillValid && !flush;
    strobe.touch     = hit && !refillValid && !flush;
    strobe.countHit  = lookupValid && hit;
    strobe.countMiss = lookupValid && !hit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      if (strobe.countHit)  hitCount  <= hitCount + 1'b1;
      if (strobe.countMiss) missCount <= missCount + 1'b1;
    end
  end

  AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec)); // R1
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && !(&validVec)) |-> !validVec[fillIdx]); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (CNT_W'(hitCount + missCount) == CNT_W'($past(hitCount) + $past(missCount) + 1'b1))); // R9
  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> ($stable(hitCount) && $stable(missCount))); // R9
endmodule

// File: rtl/tlbLru.sv
module tlbLru
  import tlbPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  output logic             hit,
  output logic [PFN_W-1:0] frame,
  output logic             refillReq,
  input  logic             refillValid,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PFN_W-1:0] refillPfn,
  input  logic             flush,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);
  localparam int IDX_W = $clog2(ENTRIES);

  tlbStrobeT                strobe;
  logic [IDX_W-1:0]         fillIdx;
  logic [IDX_W-1:0]         touchIdx;
  logic [ENTRIES-1:0]       validVec;
  logic [ENTRIES-1:0]       matchVec;
  logic [ENTRIES*IDX_W-1:0] rankFlat;

  tlbDatapath #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_datapath (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .refillVpn(refillVpn), .refillPfn(refillPfn), .strobe(strobe),
    .fillIdx(fillIdx), .touchIdx(touchIdx), .validVec(validVec),
    .matchVec(matchVec), .rankFlat(rankFlat), .hit(hit), .frame(frame)
  );

  tlbControl #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_control (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .refillValid(refillValid),
    .flush(flush), .validVec(validVec), .matchVec(matchVec), .rankFlat(rankFlat),
    .hit(hit), .strobe(strobe), .fillIdx(fillIdx), .touchIdx(touchIdx),
    .hitCount(hitCount), .missCount(missCount)
  );

  assign refillReq = lookupValid && !hit;

  AST_MISS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    refillReq |-> (lookupValid && !hit)); // R3
endmodule

// File: tb/tlbLru_bench.sv
`timescale 1ns/1ps
module tlbLru_bench;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [19:0] lookupVpn = '0;
  logic        hit;
  logic [19:0] frame;
  logic        refillReq;
  logic        refillValid = 1'b0;
  logic [19:0] refillVpn = '0;
  logic [19:0] refillPfn = '0;
  logic        flush = 1'b0;
  logic [15:0] hitCount;
  logic [15:0] missCount;

  always #2.5 clk = ~clk;

  tlbLru u_tlbLru (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .hit(hit), .frame(frame), .refillReq(refillReq), .refillValid(refillValid),
    .refillVpn(refillVpn), .refillPfn(refillPfn), .flush(flush),
    .hitCount(hitCount), .missCount(missCount)
  );

  int total = 0;
  int failed = 0;
  bit finished = 0;

  logic [19:0] mVpn [N];
  logic [19:0] mPfn [N];
  bit          mValid [N];
  int          mRank [N];
  int          expHits = 0;
  int          expMisses = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void mReset();
    for (int i = 0; i < N; i++) begin
      mValid[i] = 0;
      mRank[i] = i;
    end
  endfunction

  function automatic void mMove(input int k);
    int old = mRank[k];
    for (int i = 0; i < N; i++)
      if (i != k && mRank[i] < old) mRank[i]++;
    mRank[k] = 0;
  endfunction

  function automatic int mFind(input logic [19:0] v);
    for (int i = 0; i < N; i++)
      if (mValid[i] && mVpn[i] == v) return i;
    return -1;
  endfunction

  function automatic int mVictim();
    for (int i = 0; i < N; i++)
      if (!mValid[i]) return i;
    for (int i = 0; i < N; i++)
      if (mRank[i] == N - 1) return i;
    return 0;
  endfunction

  function automatic logic [19:0] pfnOf(input logic [19:0] v);
    return 20'(v * 3 + 20'h1_0000);
  endfunction

  task automatic look(input logic [19:0] v, output bit wasHit);
    int k = mFind(v);
    @(negedge clk);
    lookupValid = 1'b1;
    lookupVpn = v;
    #1;
    chk(hit == (k >= 0), (k >= 0) ? "R1 hit" : "R2 miss", hit, k >= 0);
    if (k >= 0) chk(frame == mPfn[k], "R1 frame", frame, mPfn[k]);
    chk(refillReq == (k < 0), "R3 refillReq", refillReq, k < 0);
    @(posedge clk);
    if (k >= 0) begin
      mMove(k);
      expHits++;
    end else expMisses++;
    wasHit = (k >= 0);
    #1 lookupValid = 1'b0;
  endtask

  task automatic refill(input logic [19:0] v, input bit withFlush);
    int k = mVictim();
    @(negedge clk);
    refillValid = 1'b1;
    refillVpn = v;
    refillPfn = pfnOf(v);
    flush = withFlush;
    @(posedge clk);
    if (withFlush) mReset();
    else begin
      mVpn[k] = v;
      mPfn[k] = pfnOf(v);
      mValid[k] = 1;
      mMove(k);
    end
    #1;
    refillValid = 1'b0;
    flush = 1'b0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    mReset();
    #1 flush = 1'b0;
  endtask

  task automatic checkCounts(input string tag);
    @(negedge clk);
    chk(hitCount == 16'(expHits), {tag, " R9 hitCount"}, hitCount, expHits);
    chk(missCount == 16'(expMisses), {tag, " R9 missCount"}, missCount, expMisses);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    bit h;
    logic [31:0] lcg = 32'h1234_5678;
    mReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R2: after reset every lookup misses; R9 counters start at zero
    checkCounts("reset");
    for (int v = 0; v < 4; v++) look(20'(v), h);

    // R4/R6: fill all free entries in index order, then hit each
    for (int v = 0; v < N; v++) refill(20'(16'hA000 + v), 1'b0);
    for (int v = 0; v < N; v++) begin
      look(20'(16'hA000 + v), h);
      chk(h, "R4 installed page hits", h, 1);
    end

    // R5/R6: touch all but one page; the next refill must evict it
    for (int v = 1; v < N; v++) look(20'(16'hA000 + v), h);
    refill(20'hBEEF0, 1'b0);
    look(20'hA000, h);
    chk(!h, "R6 least recent evicted", h, 0);
    look(20'hA001, h);
    chk(h, "R5 recent page kept", h, 1);
    checkCounts("lru");

    // R5/R6/R1: long sweep over more pages than entries
    for (int s = 0; s < 1500; s++) begin
      logic [19:0] v;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      v = 20'(20'h40 + (lcg[23:16] % 8'd13));
      look(v, h);
      if (!h) refill(v, 1'b0);
    end
    checkCounts("sweep");

    // R7: flush invalidates every page
    doFlush();
    for (int s = 0; s < 13; s++) look(20'(20'h40 + s), h);

    // R8: flush beats refill in the same cycle
    refill(20'h77777, 1'b1);
    look(20'h77777, h);
    chk(!h, "R8 refill dropped under flush", h, 0);

    // R6: after flush, free entries fill first; ninth refill evicts the first
    for (int v = 0; v < N; v++) refill(20'(20'hC000 + v), 1'b0);
    refill(20'hC0FF, 1'b0);
    look(20'hC000, h);
    chk(!h, "R6 first filled evicted", h, 0);
    for (int v = 1; v < N; v++) look(20'(20'hC000 + v), h);
    look(20'hC0FF, h);
    chk(h, "R4 new page hits", h, 1);
    checkCounts("final");

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule